// File: doc/BRIEF.md
# Memory Interface with Address-Map Decoding

This block sits between a 32-bit load/store core and its memory and I/O targets. The core presents a request with a byte address, a direction, a size (one byte or a full four-byte word) and a flag that says whether the request comes from user mode. The block checks the alignment of word requests. It splits the address space into a protected low system region, a user region above it, and a memory-mapped I/O window that covers the upper half of the space. For each accepted request it raises exactly one region select. It places the bytes in big-endian order, so the byte at the lowest address sits in the most significant lane.

Targets see the word-aligned address, a write strobe, four byte enables and the steered write data, all in the request cycle. They return read data in the same cycle. The block registers its response. In the cycle after a request it raises a ready pulse, and with it the read data and any error flag. A word access that is not aligned is blocked and flagged. A store from user mode into the system region is blocked and flagged as well. Nothing reaches a target in either case.

Top module: `mem_gate`

## Requirements
- R1: During a request that is not misaligned, exactly one select is high: `sel_os` when the address is below 2048, `sel_io` when address bit 31 is 1, and `sel_user` otherwise. No select is high when there is no request or when the request is a misaligned word.
- R2: A word request (`req_byte`=0) whose address bits 1..0 are not 00 drives no select and no `mem_we`. It raises `err_misalign` together with ready, and returns read data 0.
- R3: A byte store drives exactly one byte enable: offset 0 → `mem_be`=4'b1000, 1 → 4'b0100, 2 → 4'b0010, 3 → 4'b0001. The byte is copied into all four lanes of `mem_wdata`. A word store drives `mem_be`=4'b1111.
- R4: A byte load returns, zero-extended in bits 7..0, the memory byte in bits [31-8k : 24-8k], where k is address bits 1..0.
- R5: A word load returns the 32-bit memory word unchanged. A word store drives `req_wdata` unchanged onto `mem_wdata`.
- R6: A store with `req_user`=1 to an address below 2048 issues no `mem_we` and raises `err_protect` for one cycle with ready. The following are still carried out:
  - the same store from supervisor mode;
  - a user store to the user region;
  - a user load from the system region.
- R7: `rsp_ready` is high in exactly the cycle after each request and low after a cycle with no request. The error flags are high only while `rsp_ready` is high.
- R8: During and right after reset, `rsp_ready`, `err_misalign` and `err_protect` are low and `rsp_rdata` is 0.
- R9: `mem_addr` equals the request address with bits 1..0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_user | input | 1 | Request issued from user mode |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data (a byte store uses bits 7..0) |
| rsp_ready | output | 1 | Response cycle, one cycle after the request |
| rsp_rdata | output | 32 | Load result, valid with ready |
| err_misalign | output | 1 | Misaligned word access, valid with ready |
| err_protect | output | 1 | User store into the system region, valid with ready |
| sel_os | output | 1 | System region select |
| sel_user | output | 1 | User region select |
| sel_io | output | 1 | I/O window select |
| mem_addr | output | 32 | Word-aligned target address |
| mem_we | output | 1 | Write strobe to the selected target |
| mem_be | output | 4 | Byte enables, bit 3 = lowest byte address |
| mem_wdata | output | 32 | Steered store data |
| mem_rdata | input | 32 | Read data from the selected target, same cycle |

## Verification
A wrong region boundary shows up at once on the select outputs in the request cycle. A wrong lane mapping shows up in the same cycle on `mem_be` and `mem_wdata`. On a later word read-back it also shows as a corrupted word that the reference memory model does not predict. A fault in the misalignment or protection gating can show in two places: as a strobe in the request cycle, or as a missing or stray error flag on the ready cycle that follows. The sweeps cover each byte offset, each region and each privilege, so any such fault appears within two cycles of the access that triggers it.

// File: rtl/mg_pkg.sv
// Package: shared types for the memory interface.
// Assumes: three fixed regions plus a "none" code for blocked requests.
package mg_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_OS   = 2'd1,
        RGN_USER = 2'd2,
        RGN_IO   = 2'd3
    } region_e;
endpackage

// File: rtl/mg_align_chk.sv
// Alignment checker: flags a word access whose low offset bits are non-zero.
// Assumes: byte accesses are always aligned; OFF_W is log2 of bytes per word.
module mg_align_chk #(
    parameter int AW    = 32,
    parameter int OFF_W = 2
) (
    input  logic [AW-1:0] addr,
    input  logic          is_byte,
    output logic          misalign
);
    // purpose: a word needs every offset bit cleared
    always_comb begin
        misalign = !is_byte && (addr[OFF_W-1:0] != '0);
    end
endmodule

// File: rtl/mg_region_dec.sv
// Region decoder: maps a byte address onto the fixed system/user/I/O map.
// Assumes: IO_BASE > OS_LIMIT; the I/O window runs from IO_BASE to the top.
module mg_region_dec
    import mg_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int unsigned OS_LIMIT = 2048,
    parameter logic [AW-1:0] IO_BASE = 32'h8000_0000
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    localparam logic [AW-1:0] OS_TOP = AW'(OS_LIMIT);

    // purpose: upper window first, then the protected low region, else user
    always_comb begin
        if (addr >= IO_BASE)
            region = RGN_IO;
        else if (addr < OS_TOP)
            region = RGN_OS;
        else
            region = RGN_USER;
    end
endmodule

// File: rtl/mg_lane_steer.sv
// Lane steering: big-endian byte enables, store replication and load extraction.
// Assumes: byte offset 0 is the most significant lane of the word.
module mg_lane_steer #(
    parameter int DW = 32
) (
    input  logic [$clog2(DW/8)-1:0] offset,
    input  logic                    is_byte,
    input  logic [DW-1:0]           wdata_in,
    input  logic [DW-1:0]           rdata_mem,
    output logic [DW/8-1:0]         be,
    output logic [DW-1:0]           wdata_out,
    output logic [DW-1:0]           rdata_out
);
    localparam int LANES = DW / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(LANES - 1);

    logic [7:0]       lane_byte [LANES];
    logic [OFF_W-1:0] pick;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // purpose: enable lane j when it is the addressed byte or for any word
        always_comb begin
            be[j] = !is_byte || (offset == (LAST - OFF_W'(j)));
        end
        // purpose: byte stores copy bits 7..0 into every lane
        always_comb begin
            wdata_out[j*8 +: 8] = is_byte ? wdata_in[7:0] : wdata_in[j*8 +: 8];
        end
        // purpose: split the returned word into lanes for extraction
        always_comb begin
            lane_byte[j] = rdata_mem[j*8 +: 8];
        end
    end

    // purpose: big-endian lane index for the addressed byte
    always_comb begin
        pick = LAST - offset;
    end

    // purpose: zero-extend the addressed byte, or pass the full word
    always_comb begin
        if (is_byte)
            rdata_out = {{(DW-8){1'b0}}, lane_byte[pick]};
        else
            rdata_out = rdata_mem;
    end
endmodule

// File: rtl/mem_gate.sv
// Memory interface top: alignment check, region decode with user-mode
// write protection, big-endian lane steering and a one-cycle ready response.
// Assumes: targets answer combinationally in the request cycle; synchronous
// active-low reset.
module mem_gate
    import mg_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter int unsigned   OS_LIMIT = 2048,
    parameter logic [AW-1:0] IO_BASE  = 32'h8000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_byte,
    input  logic            req_user,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_ready,
    output logic [DW-1:0]   rsp_rdata,
    output logic            err_misalign,
    output logic            err_protect,
    output logic            sel_os,
    output logic            sel_user,
    output logic            sel_io,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int LANES = DW / 8;
    localparam int OFF_W = $clog2(LANES);

    logic          misalign;
    region_e       region;
    logic          accept;
    logic          protect_hit;
    logic [DW-1:0] load_data;

    mg_align_chk #(.AW(AW), .OFF_W(OFF_W)) u_align (
        .addr     (req_addr),
        .is_byte  (req_byte),
        .misalign (misalign)
    );

    mg_region_dec #(.AW(AW), .OS_LIMIT(OS_LIMIT), .IO_BASE(IO_BASE)) u_dec (
        .addr   (req_addr),
        .region (region)
    );

    mg_lane_steer #(.DW(DW)) u_steer (
        .offset    (req_addr[OFF_W-1:0]),
        .is_byte   (req_byte),
        .wdata_in  (req_wdata),
        .rdata_mem (mem_rdata),
        .be        (mem_be),
        .wdata_out (mem_wdata),
        .rdata_out (load_data)
    );

    // purpose: a request goes to a target unless it is a misaligned word
    always_comb begin
        accept      = req_valid && !misalign;
        protect_hit = accept && req_write && req_user && (region == RGN_OS);
    end

    // purpose: one region select per accepted request
    always_comb begin
        sel_os   = accept && (region == RGN_OS);
        sel_user = accept && (region == RGN_USER);
        sel_io   = accept && (region == RGN_IO);
    end

    // purpose: word-aligned address and write strobe suppressed by protection
    always_comb begin
        mem_addr = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
        mem_we   = accept && req_write && !protect_hit;
    end

    // purpose: registered response with errors and load data aligned to ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ready    <= 1'b0;
            rsp_rdata    <= '0;
            err_misalign <= 1'b0;
            err_protect  <= 1'b0;
        end else begin
            rsp_ready    <= req_valid;
            rsp_rdata    <= (accept && !req_write) ? load_data : '0;
            err_misalign <= req_valid && misalign;
            err_protect  <= protect_hit;
        end
    end
endmodule

// File: rtl/mg_checker.sv
// Checker: temporal properties of the memory interface, bound to mem_gate.
// Assumes: port names match the top module so implicit connection applies.
module mg_checker #(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter int unsigned OS_LIMIT = 2048
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic            req_byte,
    input logic            req_user,
    input logic [AW-1:0]   req_addr,
    input logic            rsp_ready,
    input logic            err_misalign,
    input logic            err_protect,
    input logic            sel_os,
    input logic            sel_user,
    input logic            sel_io,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_we,
    input logic [DW/8-1:0] mem_be
);
    localparam logic [AW-1:0] OS_TOP = AW'(OS_LIMIT);

    // R1: never more than one region select
    a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_os, sel_user, sel_io}));

    // R1: no select without a request
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(sel_os || sel_user || sel_io || mem_we));

    // R2: a misaligned word request is flagged on the next cycle
    a_r2_misalign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_byte && (req_addr[1:0] != 2'b00)) |=> err_misalign);

    // R2: a misaligned word request reaches no target
    a_r2_misalign_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_byte && (req_addr[1:0] != 2'b00))
            |-> !(sel_os || sel_user || sel_io || mem_we));

    // R3: a byte store strobes a single lane
    a_r3_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && req_byte) |-> ($countones(mem_be) == 1));

    // R6: no write strobe for a user store into the system region
    a_r6_protect_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_user && (req_addr < OS_TOP)) |-> !mem_we);

    // R7: ready follows every request by one cycle
    a_r7_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    // R7: no ready after an idle cycle
    a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);

    // R7: error flags only alongside ready
    a_r7_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (err_misalign || err_protect) |-> rsp_ready);

    // R9: target address is always word aligned
    a_r9_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[1:0] == 2'b00);
endmodule

bind mem_gate mg_checker #(.AW(AW), .DW(DW), .OS_LIMIT(OS_LIMIT)) u_chk (.*);

// File: tb/mem_gate_bench.sv
`timescale 1ns/1ps
module mem_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_user = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_ready, err_misalign, err_protect;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        sel_os, sel_user, sel_io, mem_we;
    logic [3:0]  mem_be;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] mdl [48];   // target model: 16 words per region
    logic [31:0] shd [48];   // expected contents, kept by the bench

    always #2 clk = ~clk;    // 250 MHz

    mem_gate u_mem_gate (.*);

    // target model: region picked by the selects, word index from bits 5..2
    function automatic int mdl_idx();
        int base = sel_os ? 0 : (sel_user ? 16 : 32);
        return base + int'(mem_addr[5:2]);
    endfunction

    always_comb begin
        if (sel_os || sel_user || sel_io) mem_rdata = mdl[mdl_idx()];
        else mem_rdata = 32'h0;
    end

    always @(posedge clk) begin
        if (mem_we) begin
            for (int j = 0; j < 4; j++)
                if (mem_be[j]) mdl[mdl_idx()][j*8 +: 8] <= mem_wdata[j*8 +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench's own map: 0 = system, 1 = user, 2 = I/O
    function automatic int rgn_of(input logic [31:0] a);
        if (a[31]) return 2;
        if (a < 32'd2048) return 0;
        return 1;
    endfunction

    // one request, then one idle cycle
    task automatic access(input bit w, input bit b, input bit u,
                          input logic [31:0] a, input logic [31:0] d);
        int          r   = rgn_of(a);
        int          si  = r * 16 + int'(a[5:2]);
        bit          mis = !b && (a[1:0] != 2'b00);
        bit          prot = w && u && (r == 0) && !mis;
        bit          we  = w && !mis && !prot;
        logic [2:0]  esel = mis ? 3'b000 : (r == 0 ? 3'b100 : (r == 1 ? 3'b010 : 3'b001));
        logic [3:0]  ebe  = b ? (4'b1000 >> a[1:0]) : 4'hF;
        logic [31:0] ewd  = b ? {4{d[7:0]}} : d;
        logic [31:0] erd  = 32'h0;
        int          sh   = 8 * (3 - int'(a[1:0]));
        if (!w && !mis) erd = b ? ((shd[si] >> sh) & 32'hFF) : shd[si];
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_byte = b; req_user = u;
        req_addr = a; req_wdata = d;
        #1;
        chk({sel_os, sel_user, sel_io} == esel, "R1 selects", {29'b0, sel_os, sel_user, sel_io}, {29'b0, esel});
        chk(mem_we == we, mis ? "R2 no strobe" : (prot ? "R6 strobe gating" : "R6 allowed strobe"),
            {31'b0, mem_we}, {31'b0, we});
        chk(mem_addr == {a[31:2], 2'b00}, "R9 word address", mem_addr, {a[31:2], 2'b00});
        if (we) begin
            chk(mem_be == ebe, "R3 byte enables", {28'b0, mem_be}, {28'b0, ebe});
            chk(mem_wdata == ewd, b ? "R3 lane copy" : "R5 word store data", mem_wdata, ewd);
        end
        @(posedge clk); #1;
        chk(rsp_ready == 1'b1, "R7 ready after request", {31'b0, rsp_ready}, 32'h1);
        chk(err_misalign == mis, "R2 misalign flag", {31'b0, err_misalign}, {31'b0, mis});
        chk(err_protect == prot, "R6 protect flag", {31'b0, err_protect}, {31'b0, prot});
        chk(rsp_rdata == erd, b ? "R4 byte load" : "R5 word load", rsp_rdata, erd);
        if (we) begin
            if (b) shd[si][sh +: 8] = d[7:0];
            else shd[si] = d;
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk(rsp_ready == 1'b0, "R7 no ready when idle", {31'b0, rsp_ready}, 32'h0);
        chk(!err_protect && !err_misalign, "R7 errors only with ready",
            {30'b0, err_protect, err_misalign}, 32'h0);
    endtask

    function automatic logic [31:0] base_of(input int r);
        return r == 0 ? 32'h0000_0000 : (r == 1 ? 32'h0000_0800 : 32'h8000_0000);
    endfunction

    initial begin
        for (int i = 0; i < 48; i++) begin mdl[i] = 32'h0; shd[i] = 32'h0; end
        repeat (3) @(posedge clk);
        #1;
        chk(!rsp_ready && !err_misalign && !err_protect, "R8 reset flags",
            {29'b0, rsp_ready, err_misalign, err_protect}, 32'h0);
        chk(rsp_rdata == 32'h0, "R8 reset data", rsp_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!rsp_ready && rsp_rdata == 32'h0, "R8 after reset",
            rsp_rdata | {31'b0, rsp_ready}, 32'h0);

        // R5: fill every modelled word of each region, then read back
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 16; i++)
                access(1, 0, 0, base_of(r) + 32'(i * 4), 32'h1357_9BDF * 32'(r * 16 + i + 1));
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 16; i++)
                access(0, 0, r == 1, base_of(r) + 32'(i * 4), 32'h0);

        // R3, R4: byte sweep over every offset, loads before and after stores
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < 4; i++)
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] a = base_of(r) + 32'(i * 4 + k);
                    access(0, 1, 0, a, 32'h0);
                    access(1, 1, 0, a, 32'hA0 + 32'(r * 16 + i * 4 + k));
                    access(0, 1, 1, a, 32'h0);
                    access(0, 0, 0, {a[31:2], 2'b00}, 32'h0);
                end

        // R2: misaligned words in each region, both directions, then read-back
        for (int r = 0; r < 3; r++)
            for (int k = 1; k < 4; k++) begin
                access(0, 0, 0, base_of(r) + 32'(20 + k), 32'h0);
                access(1, 0, 0, base_of(r) + 32'(20 + k), 32'hDEAD_BEEF);
                access(0, 0, 0, base_of(r) + 32'd20, 32'h0);
            end

        // R6: user stores into the system region are blocked; others pass
        for (int k = 0; k < 4; k++) begin
            access(1, 0, 1, 32'h0000_0010, 32'hBAD0_0000 + 32'(k));
            access(1, 1, 1, 32'h0000_0010 + 32'(k), 32'h55);
            access(0, 0, 1, 32'h0000_0010, 32'h0);
        end
        access(1, 0, 1, 32'h0000_0804, 32'h0C0F_FEE0);
        access(0, 0, 1, 32'h0000_0804, 32'h0);
        access(1, 0, 1, 32'h8000_0008, 32'h1010_2020);
        access(0, 0, 1, 32'h8000_0008, 32'h0);
        access(1, 0, 0, 32'h0000_0010, 32'h600D_0001);
        access(0, 0, 1, 32'h0000_0010, 32'h0);

        // R1: boundary addresses of the map
        access(1, 0, 0, 32'h0000_07FC, 32'h0000_07FC);
        access(1, 1, 1, 32'h0000_07FF, 32'h77);
        access(1, 0, 1, 32'h0000_0800, 32'h0000_0800);
        access(1, 0, 1, 32'h7FFF_FFFC, 32'h7FFF_FFFC);
        access(0, 1, 1, 32'h7FFF_FFFF, 32'h0);
        access(1, 0, 1, 32'h8000_0000, 32'h8000_0000);
        access(1, 0, 1, 32'hFFFF_FFFC, 32'hFFFF_FFFC);
        access(0, 1, 1, 32'hFFFF_FFFF, 32'h0);
        access(0, 0, 1, 32'h0000_07FC, 32'h0);
        access(0, 0, 1, 32'h7FFF_FFFC, 32'h0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule